// File: doc/BRIEF.md
# Line-Sync Clamp Window and Sync Regenerator

This block runs on the pixel clock. It watches an incoming horizontal sync line and produces two outputs. The first is a black-level clamp pulse that opens a programmable number of pixel periods after the sync pulse ends and stays open for a programmable number of pixel periods. The second is a cleaned-up, active-high copy of the sync pulse whose width in pixel clocks is programmable. A select input can bypass the internal clamp timing, so that the clamp output copies an external clamp input instead.

The incoming sync passes through a two-flop synchronizer. Its active level is chosen by a polarity input. The placement and duration settings are captured at each detected sync end, so a register update made partway through a line only affects the next line. A setting of zero is not a legal programming value, and the block treats it as one.

Top module: `clampgen_top`

## Requirements
- R1: When `hs_in` is first sampled inactive at rising edge k, the internal clamp is first high after edge k+1+N, where N is `clamp_delay`.
- R2: The internal clamp stays high for exactly M consecutive clock cycles, where M is `clamp_len`, and then goes low.
- R3: A value of 0 in `clamp_delay`, `clamp_len` or `hs_width` behaves exactly like a value of 1.
- R4: While `clamp_ext_sel` is 1, `clamp_out` equals `clamp_ext` in the same cycle, and `clamp_delay` and `clamp_len` have no effect on it.
- R5: When `hs_in` is first sampled active at edge k, `hs_out` is high after edges k+2 through k+1+W, where W is `hs_width`. A new sync start during a pulse restarts the count. `hs_out` is active high whatever the input polarity.
- R6: `hs_pol` = 1 means `hs_in` is active high, and `hs_pol` = 0 means it is active low. Only the active-to-inactive transition starts a clamp window.
- R7: `clamp_delay` and `clamp_len` are captured at the cycle in which the sync end is recognised. Later changes do not alter the window already scheduled.
- R8: A sync end that is recognised while a clamp window is pending or open ends any clamp in progress and schedules a new window from that sync end.
- R9: During reset and afterwards, both outputs are low. No sync edge is recognised on the first three clock edges after reset. No clamp is produced until a sync start has been followed by a sync end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_in | input | 1 | Incoming horizontal sync, asynchronous |
| hs_pol | input | 1 | 1: sync active high, 0: sync active low |
| clamp_ext_sel | input | 1 | 1: clamp output follows `clamp_ext` |
| clamp_ext | input | 1 | External clamp request |
| clamp_delay | input | 8 | Pixel periods from sync end to clamp start |
| clamp_len | input | 8 | Clamp length in pixel periods |
| hs_width | input | 8 | Regenerated sync width in pixel periods |
| clamp_out | output | 1 | Clamp pulse, active high |
| hs_out | output | 1 | Regenerated sync pulse, active high |

## Verification
A wrong counter or a wrong state in the clamp timer shows up on `clamp_out` within the current line. The window opens or closes one or more cycles away from the expected edge, or a second sync end fails to cut an open window short. A capture fault (latching the settings at the wrong time) shows only on the line after a register change made partway through a line, so stimulus changes the settings during open windows. A synchronizer or edge-detector fault moves both outputs by whole cycles, or fires them on the wrong polarity, from the very first line after reset.

// File: rtl/clampgen_pkg.sv
package clampgen_pkg;

    localparam int CFG_W = 8;

    typedef logic [CFG_W-1:0] cfg_t;

    typedef enum logic [1:0] {
        CL_IDLE,
        CL_WAIT,
        CL_ON
    } clamp_st_e;

    typedef struct packed {
        logic lead;
        logic trail;
    } hs_evt_t;

    // Illegal zero setting is promoted to the smallest legal value.
    function automatic cfg_t floor_one(input cfg_t v);
        return (v == '0) ? cfg_t'(1) : v;
    endfunction

endpackage

// File: rtl/hs_edge_det.sv
module hs_edge_det
    import clampgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    hs_raw,
    input  logic    pol_hi,
    output hs_evt_t evt,
    output logic    armed
);
    localparam int WARM_N = SYNC_STAGES + 1;
    localparam int WARM_W = $clog2(WARM_N + 1);

    logic [SYNC_STAGES-1:0] sy;
    logic                   act, act_q, ready;
    logic [WARM_W-1:0]      warm;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sy <= '0;
                else     sy <= hs_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sy <= '0;
                else     sy <= {sy[SYNC_STAGES-2:0], hs_raw};
            end
        end
    endgenerate

    assign act   = pol_hi ? sy[SYNC_STAGES-1] : ~sy[SYNC_STAGES-1];
    assign ready = (warm == WARM_W'(WARM_N));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= 1'b0;
            warm  <= '0;
            armed <= 1'b0;
        end else begin
            act_q <= act;
            if (!ready) warm <= warm + 1'b1;
            if (evt.lead) armed <= 1'b1;
        end
    end

    assign evt.lead  = ready &  act & ~act_q;
    assign evt.trail = ready & ~act &  act_q;

    p_armed_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        armed |=> armed);
    p_no_edge_cold_r9: assert property (@(posedge clk) disable iff (rst)
        (warm != WARM_W'(WARM_N)) |-> !(evt.lead || evt.trail));

endmodule

// File: rtl/clamp_timer.sv
module clamp_timer
    import clampgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic trail,
    input  logic armed,
    input  cfg_t place,
    input  cfg_t dur,
    output logic clamp_int
);
    clamp_st_e st;
    cfg_t      cnt, n_lat, m_lat, n_eff, m_eff;
    logic      go;

    assign go    = trail & armed;
    assign n_eff = floor_one(place);
    assign m_eff = floor_one(dur);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= CL_IDLE;
            cnt   <= '0;
            n_lat <= cfg_t'(1);
            m_lat <= cfg_t'(1);
        end else if (go) begin
            n_lat <= n_eff;
            m_lat <= m_eff;
            if (n_eff == cfg_t'(1)) begin
                st  <= CL_ON;
                cnt <= m_eff;
            end else begin
                st  <= CL_WAIT;
                cnt <= n_eff - 1'b1;
            end
        end else begin
            case (st)
                CL_WAIT: begin
                    if (cnt == cfg_t'(1)) begin
                        st  <= CL_ON;
                        cnt <= m_lat;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                CL_ON: begin
                    if (cnt == cfg_t'(1)) st <= CL_IDLE;
                    else                  cnt <= cnt - 1'b1;
                end
                default: st <= CL_IDLE;
            endcase
        end
    end

    assign clamp_int = (st == CL_ON);

    p_unarmed_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !armed |-> (st == CL_IDLE));
    p_wait_to_on_r1: assert property (@(posedge clk) disable iff (rst)
        (st == CL_WAIT && cnt == cfg_t'(1) && !go) |=> (st == CL_ON));
    p_on_ends_r2: assert property (@(posedge clk) disable iff (rst)
        (st == CL_ON && cnt == cfg_t'(1) && !go) |=> (st == CL_IDLE));
    p_restart_r8: assert property (@(posedge clk) disable iff (rst)
        go |=> (st == CL_WAIT || (st == CL_ON && n_lat == cfg_t'(1))));
    p_lat_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        (st != CL_IDLE) |-> (n_lat != '0 && m_lat != '0 && cnt != '0));

endmodule

// File: rtl/hs_regen.sv
module hs_regen
    import clampgen_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lead,
    input  cfg_t width,
    output logic hs_out
);
    cfg_t cnt;

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (lead)          cnt <= floor_one(width);
        else if (cnt != '0)     cnt <= cnt - 1'b1;
    end

    assign hs_out = (cnt != '0);

    p_hs_start_r5: assert property (@(posedge clk) disable iff (rst)
        lead |=> hs_out);
    p_hs_end_r5: assert property (@(posedge clk) disable iff (rst)
        (cnt == cfg_t'(1) && !lead) |=> !hs_out);

endmodule

// File: rtl/clampgen_top.sv
module clampgen_top
    import clampgen_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hs_in,
    input  logic             hs_pol,
    input  logic             clamp_ext_sel,
    input  logic             clamp_ext,
    input  logic [CFG_W-1:0] clamp_delay,
    input  logic [CFG_W-1:0] clamp_len,
    input  logic [CFG_W-1:0] hs_width,
    output logic             clamp_out,
    output logic             hs_out
);
    hs_evt_t evt;
    logic    armed, clamp_int;

    hs_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst    (rst),
        .hs_raw (hs_in),
        .pol_hi (hs_pol),
        .evt    (evt),
        .armed  (armed)
    );

    clamp_timer u_clamp (
        .clk       (clk),
        .rst       (rst),
        .trail     (evt.trail),
        .armed     (armed),
        .place     (clamp_delay),
        .dur       (clamp_len),
        .clamp_int (clamp_int)
    );

    hs_regen u_hs (
        .clk    (clk),
        .rst    (rst),
        .lead   (evt.lead),
        .width  (hs_width),
        .hs_out (hs_out)
    );

    assign clamp_out = clamp_ext_sel ? clamp_ext : clamp_int;

    p_rst_quiet_r9: assert property (@(posedge clk)
        rst |=> (!hs_out && (clamp_ext_sel || !clamp_out)));

endmodule

// File: tb/tb_clampgen_top.sv
module tb_clampgen_top;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hs_in = 1'b0, hs_pol = 1'b1;
    logic       clamp_ext_sel = 1'b0, clamp_ext = 1'b0;
    logic [7:0] clamp_delay = 8'd4, clamp_len = 8'd6, hs_width = 8'd5;
    logic       clamp_out, hs_out;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    string tag = "R9";

    clampgen_top dut (
        .clk(clk), .rst(rst), .hs_in(hs_in), .hs_pol(hs_pol),
        .clamp_ext_sel(clamp_ext_sel), .clamp_ext(clamp_ext),
        .clamp_delay(clamp_delay), .clamp_len(clamp_len), .hs_width(hs_width),
        .clamp_out(clamp_out), .hs_out(hs_out)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic int eff(input logic [7:0] v);
        return (v == 8'd0) ? 1 : int'(v);
    endfunction

    function automatic logic is_act(input logic v, input logic pol);
        return pol ? v : ~v;
    endfunction

    // Reference model: windows expressed as edge-index ranges.
    int   n, cs, ce, hs_s, hs_e;
    logic h1, h2, h3, seen, trail_p, lead_p;
    logic exp_win, exp_hs;

    always @(posedge clk) begin
        if (rst) begin
            n = 0; cs = 1; ce = 0; hs_s = 1; hs_e = 0;
            h1 = 0; h2 = 0; h3 = 0; seen = 0; trail_p = 0; lead_p = 0;
        end else begin
            n = n + 1;
            if (trail_p && seen) begin
                cs = (n - 1) + eff(clamp_delay);
                ce = cs + eff(clamp_len) - 1;
            end
            if (lead_p) begin
                seen = 1;
                hs_s = n;
                hs_e = n - 1 + eff(hs_width);
            end
            h3 = h2; h2 = h1; h1 = hs_in;
            trail_p = (n >= 3) && !is_act(h2, hs_pol) && is_act(h3, hs_pol);
            lead_p  = (n >= 3) && is_act(h2, hs_pol) && !is_act(h3, hs_pol);
        end
        exp_win = (n >= cs) && (n <= ce);
        exp_hs  = (n >= hs_s) && (n <= hs_e);
    end

    always begin
        @(posedge clk);
        #(CLK_P/4);
        n_chk++;
        if (clamp_out !== (clamp_ext_sel ? clamp_ext : exp_win)) begin
            n_fail++;
            $display("FAIL %s clamp_out act %0b exp %0b at cycle %0d", tag,
                     clamp_out, clamp_ext_sel ? clamp_ext : exp_win, cyc);
        end
        n_chk++;
        if (hs_out !== exp_hs) begin
            n_fail++;
            $display("FAIL %s hs_out act %0b exp %0b at cycle %0d", tag,
                     hs_out, exp_hs, cyc);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog act %0d exp <150000 cycles", cyc);
            $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
            $finish;
        end
    end

    task automatic wait_n(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset(input logic pol, input logic lvl);
        @(negedge clk);
        rst = 1'b1; hs_pol = pol; hs_in = lvl;
        wait_n(3);
        rst = 1'b0;
    endtask

    task automatic line(input int act_len, input int gap);
        hs_in = hs_pol; wait_n(act_len);
        hs_in = ~hs_pol; wait_n(gap);
    endtask

    initial begin
        void'($urandom(32'd1234));
        // R9: reset state and a sync end with no prior sync start
        tag = "R9";
        do_reset(1'b1, 1'b1);
        wait_n(10);
        hs_in = 1'b0; wait_n(300);
        // R1 and R2: basic window placement and length
        tag = "R1/R2";
        line(5, 300);
        clamp_delay = 8'd1; clamp_len = 8'd1; line(4, 40);
        clamp_delay = 8'd255; clamp_len = 8'd255; line(4, 520);
        // R3: zero settings behave as one
        tag = "R3";
        clamp_delay = 8'd0; clamp_len = 8'd0; hs_width = 8'd0;
        line(3, 50); line(1, 30);
        // R7: settings changed while a window is scheduled
        tag = "R7";
        clamp_delay = 8'd10; clamp_len = 8'd20; hs_width = 8'd5;
        hs_in = 1'b1; wait_n(4); hs_in = 1'b0; wait_n(6);
        clamp_delay = 8'd200; clamp_len = 8'd1; wait_n(20);
        clamp_delay = 8'd3; clamp_len = 8'd2; wait_n(300);
        // R8: new sync end while a window is pending or open
        tag = "R8";
        clamp_delay = 8'd100; clamp_len = 8'd100;
        line(3, 60); line(3, 130); line(3, 300);
        // R4: external clamp selected, internal settings ignored
        tag = "R4";
        clamp_ext_sel = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            clamp_ext = 1'($urandom);
            if (i % 50 == 0) begin
                clamp_delay = 8'($urandom); clamp_len = 8'($urandom);
            end
            hs_in = ((i % 100) < 4);
        end
        clamp_ext_sel = 1'b0; clamp_ext = 1'b0;
        hs_in = 1'b0; wait_n(300);
        // R5: regenerated sync width, including restart during a pulse
        tag = "R5";
        clamp_delay = 8'd5; clamp_len = 8'd5;
        hs_width = 8'd7; line(2, 40);
        hs_width = 8'd255; line(3, 20); line(3, 300);
        hs_width = 8'd1; line(1, 20);
        // R6: active-low input polarity
        tag = "R6";
        do_reset(1'b0, 1'b1);
        wait_n(5);
        hs_width = 8'd6; clamp_delay = 8'd8; clamp_len = 8'd9;
        line(6, 100); line(2, 60);
        // Mixed random lines over R1, R2, R3, R7, R8
        tag = "R1/R2/R3/R7/R8";
        do_reset(1'b1, 1'b0);
        wait_n(5);
        for (int l = 0; l < 80; l++) begin
            int a, g, w;
            if ($urandom % 3 == 0) clamp_delay = ($urandom % 8 == 0) ? 8'd0 : 8'($urandom);
            if ($urandom % 3 == 0) clamp_len   = ($urandom % 8 == 0) ? 8'd0 : 8'($urandom);
            if ($urandom % 3 == 0) hs_width    = 8'($urandom % 40);
            a = 1 + int'($urandom % 20);
            g = 1 + int'($urandom % 300);
            w = int'($urandom % g);
            hs_in = 1'b1; wait_n(a);
            hs_in = 1'b0; wait_n(w);
            clamp_delay = 8'($urandom); clamp_len = 8'($urandom);
            wait_n(g - w);
        end
        wait_n(600);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule